// File: doc/BRIEF.md
# Strip-Folded Matrix Multiply Engine

This block computes the product C = A x B of a matrix A with M rows and K columns and a matrix B with K rows and N columns. The dimensions are run-time inputs. The arithmetic is done by a short linear chain of multiply-accumulate cells, far fewer than the matrix width. The engine therefore folds the work: it produces one strip of NCELL adjacent result columns of one row at a time. It walks the strips left to right and the rows top to bottom.

For every step of the inner dimension, the engine requests one element of A and one row slice of B from an operand register file. That file is kept filled ahead of time by shadow logic outside this block, and it answers one cycle later. The A element enters the first cell together with the B slice. Each cell takes its own lane of the slice, starts a multiply-accumulate that occupies it for LAT cycles, and passes the whole operand bundle to its right-hand neighbour one cycle later.

Once the final partial product of a strip has left the last cell, the results are written out one word per cycle. A controller above the block sees only the start and ready handshake. The arithmetic is a 32-bit fixed-point model with a configurable latency.

Top module: `mxm_strip_engine`

## Requirements
- R1: After reset, ready is 1 and both rd_en and wr_en are 0.
- R2: A start sampled while ready is 1 captures dim_m, dim_k and dim_n.
  - ready is 0 from the next cycle onward.
  - ready stays 0 through the cycle of the last result write and returns to 1 in the cycle right after it.
- R3: A start sampled while ready is 0 has no effect: the running product keeps its captured dimensions, and its results and write count are unchanged.
- R4: Each written word equals the sum over k of A[row][k] * B[k][col], keeping the low 32 bits of every product and of the sum.
- R5: Results are written in order of increasing row, and within a row in increasing column.
  - Each (row, col) with row < M and col < N is written exactly once.
  - No write is issued for a column at or beyond N.
  - rd_en and wr_en are never 1 together.
- R6: An operand request (rd_en = 1) carries the current row, the inner index rd_k (0 to K-1 in order) and the strip base column rd_col0.
  - rd_col0 is a multiple of NCELL.
  - The following cycle the requester must supply A[rd_row][rd_k] on rd_a, and B[rd_k][rd_col0 + j] in bits [32j+31:32j] of rd_b.
- R7: Within a strip, consecutive operand requests are exactly LAT cycles apart. This is the occupancy of one multiply-accumulate.
- R8: Every accumulator clears at the first inner step of each new result element. Results never include anything left over from an earlier strip or an earlier product.
- R9: The first write of a strip comes exactly NCELL + LAT + 2 cycles after the last operand request of that strip. Write-back waits for the final partial product to drain through every cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a product; honoured only while ready is 1 |
| dim_m | input | DIM_W | Rows of A and of C (at least 1) |
| dim_k | input | DIM_W | Inner dimension (at least 1) |
| dim_n | input | DIM_W | Columns of B and of C (at least 1) |
| ready | output | 1 | Engine idle and able to accept start |
| rd_en | output | 1 | Operand request |
| rd_row | output | DIM_W | Row of A requested |
| rd_k | output | DIM_W | Inner index requested |
| rd_col0 | output | DIM_W | First B column of the requested slice |
| rd_a | input | 32 | A element, valid the cycle after rd_en |
| rd_b | input | NCELL*32 | B slice, lane j in bits [32j+31:32j], valid the cycle after rd_en |
| wr_en | output | 1 | Result write strobe |
| wr_row | output | DIM_W | Result row |
| wr_col | output | DIM_W | Result column |
| wr_data | output | 32 | Result word |

## Verification
The assertions rely on the controller raising start only with all three dimensions nonzero. They also take the operand file to answer every request in the cycle right after it, so the request spacing and range properties follow from the engine alone. The bench keeps to these limits by sweeping M from 1 to 3, K from 1 to 4 and N from 1 to 7, including widths that leave cells idle in the last strip. It drives start only from a tidy idle state, except for deliberate mid-run pulses that carry different nonzero dimensions. Its operand model returns a computed pattern exactly one cycle after each request.

// File: rtl/mxm_pkg.sv
package mxm_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_GAP,
    ST_DRAIN,
    ST_WRITE
  } seq_st_e;
endpackage

// File: rtl/mxm_cell.sv
module mxm_cell
  import mxm_pkg::*;
#(
  parameter int unsigned NCELL = 4,
  parameter int unsigned LANE  = 0,
  parameter int unsigned LAT   = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic                    in_clr,
  input  logic                    in_last,
  input  logic [WORD_W-1:0]       in_a,
  input  logic [NCELL*WORD_W-1:0] in_b,
  output logic                    out_vld,
  output logic                    out_clr,
  output logic                    out_last,
  output logic [WORD_W-1:0]       out_a,
  output logic [NCELL*WORD_W-1:0] out_b,
  output logic [WORD_W-1:0]       acc,
  output logic                    fin
);
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  logic                    fwd_vld_q, fwd_clr_q, fwd_last_q;
  logic [WORD_W-1:0]       fwd_a_q;
  logic [NCELL*WORD_W-1:0] fwd_b_q;
  logic [WORD_W-1:0]       op_a_q, op_b_q;
  logic                    op_clr_q, op_last_q;
  logic                    busy_q, busy_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [WORD_W-1:0]       acc_q, acc_d;
  logic                    acc_en;
  logic                    fin_q, fin_d;
  logic [WORD_W-1:0]       prod;

  // Lane selection and low-word product of the latched operands
  assign prod = op_a_q * op_b_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    acc_en = 1'b0;
    fin_d  = 1'b0;
    if (busy_q && (cnt_q == '0)) begin
      acc_en = 1'b1;
      acc_d  = (op_clr_q ? '0 : acc_q) + prod;
      busy_d = 1'b0;
      fin_d  = op_last_q;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (in_vld) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(LAT - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      fin_q     <= 1'b0;
      fwd_vld_q <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      fin_q     <= fin_d;
      fwd_vld_q <= in_vld;
    end
  end

  // Data registers: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (in_vld) begin
      op_a_q     <= in_a;
      op_b_q     <= in_b[LANE*WORD_W +: WORD_W];
      op_clr_q   <= in_clr;
      op_last_q  <= in_last;
      fwd_a_q    <= in_a;
      fwd_b_q    <= in_b;
      fwd_clr_q  <= in_clr;
      fwd_last_q <= in_last;
    end
    if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign out_vld  = fwd_vld_q;
  assign out_clr  = fwd_clr_q;
  assign out_last = fwd_last_q;
  assign out_a    = fwd_a_q;
  assign out_b    = fwd_b_q;
  assign acc      = acc_q;
  assign fin      = fin_q;
endmodule

// File: rtl/mxm_seq.sv
module mxm_seq
  import mxm_pkg::*;
#(
  parameter int unsigned NCELL = 4,
  parameter int unsigned LAT   = 19,
  parameter int unsigned DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] dim_m,
  input  logic [DIM_W-1:0] dim_k,
  input  logic [DIM_W-1:0] dim_n,
  input  logic             fin_last,
  output logic             ready,
  output logic             rd_en,
  output logic [DIM_W-1:0] rd_row,
  output logic [DIM_W-1:0] rd_k,
  output logic [DIM_W-1:0] rd_col0,
  output logic             iss_vld,
  output logic             iss_clr,
  output logic             iss_last,
  output logic             wr_en,
  output logic [DIM_W-1:0] wr_row,
  output logic [DIM_W-1:0] wr_col,
  output logic [$clog2(NCELL)-1:0] wr_lane
);
  localparam int unsigned LANE_W = $clog2(NCELL);
  localparam int unsigned TMR_W  = $clog2(LAT + 1);
  localparam int unsigned SUM_W  = DIM_W + 1;

  seq_st_e          st_q, st_d;
  logic [DIM_W-1:0] m_q, m_d, kd_q, kd_d, n_q, n_d;
  logic [DIM_W-1:0] row_q, row_d, k_q, k_d, col0_q, col0_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             iss_vld_q, iss_clr_q, iss_last_q;
  logic             k_last, row_last, lane_end, strip_end;
  logic [SUM_W-1:0] col_sum;

  assign k_last    = (k_q == kd_q - 1'b1);
  assign row_last  = (row_q == m_q - 1'b1);
  assign col_sum   = {1'b0, col0_q} + SUM_W'(lane_q);
  assign lane_end  = (lane_q == LANE_W'(NCELL - 1)) ||
                     ((col_sum + SUM_W'(1)) >= {1'b0, n_q});
  assign strip_end = (({1'b0, col0_q} + SUM_W'(NCELL)) >= {1'b0, n_q});

  always_comb begin
    st_d   = st_q;
    m_d    = m_q;
    kd_d   = kd_q;
    n_d    = n_q;
    row_d  = row_q;
    k_d    = k_q;
    col0_d = col0_q;
    lane_d = lane_q;
    tmr_d  = tmr_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          m_d    = dim_m;
          kd_d   = dim_k;
          n_d    = dim_n;
          row_d  = '0;
          k_d    = '0;
          col0_d = '0;
          st_d   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        tmr_d = TMR_W'(LAT - 1);
        if (k_last) begin
          st_d = ST_DRAIN;
        end else begin
          k_d  = k_q + 1'b1;
          st_d = (LAT > 1) ? ST_GAP : ST_ISSUE;
        end
      end
      ST_GAP: begin
        if (tmr_q <= TMR_W'(1)) st_d = ST_ISSUE;
        else                    tmr_d = tmr_q - 1'b1;
      end
      ST_DRAIN: begin
        if (fin_last) begin
          lane_d = '0;
          st_d   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (lane_end) begin
          k_d = '0;
          if (strip_end) begin
            col0_d = '0;
            if (row_last) begin
              st_d = ST_IDLE;
            end else begin
              row_d = row_q + 1'b1;
              st_d  = ST_ISSUE;
            end
          end else begin
            col0_d = col0_q + DIM_W'(NCELL);
            st_d   = ST_ISSUE;
          end
        end else begin
          lane_d = lane_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      m_q        <= '0;
      kd_q       <= '0;
      n_q        <= '0;
      row_q      <= '0;
      k_q        <= '0;
      col0_q     <= '0;
      lane_q     <= '0;
      tmr_q      <= '0;
      iss_vld_q  <= 1'b0;
      iss_clr_q  <= 1'b0;
      iss_last_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      m_q        <= m_d;
      kd_q       <= kd_d;
      n_q        <= n_d;
      row_q      <= row_d;
      k_q        <= k_d;
      col0_q     <= col0_d;
      lane_q     <= lane_d;
      tmr_q      <= tmr_d;
      iss_vld_q  <= (st_q == ST_ISSUE);
      iss_clr_q  <= (k_q == '0);
      iss_last_q <= k_last;
    end
  end

  assign ready    = (st_q == ST_IDLE);
  assign rd_en    = (st_q == ST_ISSUE);
  assign rd_row   = row_q;
  assign rd_k     = k_q;
  assign rd_col0  = col0_q;
  assign iss_vld  = iss_vld_q;
  assign iss_clr  = iss_clr_q;
  assign iss_last = iss_last_q;
  assign wr_en    = (st_q == ST_WRITE);
  assign wr_row   = row_q;
  assign wr_col   = col_sum[DIM_W-1:0];
  assign wr_lane  = lane_q;
endmodule

// File: rtl/mxm_strip_engine.sv
module mxm_strip_engine
  import mxm_pkg::*;
#(
  parameter int unsigned NCELL = 4,
  parameter int unsigned LAT   = 19,
  parameter int unsigned DIM_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DIM_W-1:0]        dim_m,
  input  logic [DIM_W-1:0]        dim_k,
  input  logic [DIM_W-1:0]        dim_n,
  output logic                    ready,
  output logic                    rd_en,
  output logic [DIM_W-1:0]        rd_row,
  output logic [DIM_W-1:0]        rd_k,
  output logic [DIM_W-1:0]        rd_col0,
  input  logic [WORD_W-1:0]       rd_a,
  input  logic [NCELL*WORD_W-1:0] rd_b,
  output logic                    wr_en,
  output logic [DIM_W-1:0]        wr_row,
  output logic [DIM_W-1:0]        wr_col,
  output logic [WORD_W-1:0]       wr_data
);
  localparam int unsigned LANE_W = $clog2(NCELL);

  // Reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic                    iss_vld, iss_clr, iss_last, fin_last;
  logic [LANE_W-1:0]       wr_lane;
  logic                    c_vld  [NCELL+1];
  logic                    c_clr  [NCELL+1];
  logic                    c_last [NCELL+1];
  logic [WORD_W-1:0]       c_a    [NCELL+1];
  logic [NCELL*WORD_W-1:0] c_b    [NCELL+1];
  logic [WORD_W-1:0]       acc_v  [NCELL];
  logic [NCELL-1:0]        fin_v;
  logic                    chain_unused;

  mxm_seq #(.NCELL(NCELL), .LAT(LAT), .DIM_W(DIM_W)) seq_i (
    .clk(clk), .rst_n(rst_s2_q), .start(start),
    .dim_m(dim_m), .dim_k(dim_k), .dim_n(dim_n), .fin_last(fin_last),
    .ready(ready), .rd_en(rd_en), .rd_row(rd_row), .rd_k(rd_k),
    .rd_col0(rd_col0), .iss_vld(iss_vld), .iss_clr(iss_clr),
    .iss_last(iss_last), .wr_en(wr_en), .wr_row(wr_row),
    .wr_col(wr_col), .wr_lane(wr_lane)
  );

  assign c_vld[0]  = iss_vld;
  assign c_clr[0]  = iss_clr;
  assign c_last[0] = iss_last;
  assign c_a[0]    = rd_a;
  assign c_b[0]    = rd_b;

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    mxm_cell #(.NCELL(NCELL), .LANE(g), .LAT(LAT)) cell_i (
      .clk(clk), .rst_n(rst_s2_q),
      .in_vld(c_vld[g]), .in_clr(c_clr[g]), .in_last(c_last[g]),
      .in_a(c_a[g]), .in_b(c_b[g]),
      .out_vld(c_vld[g+1]), .out_clr(c_clr[g+1]), .out_last(c_last[g+1]),
      .out_a(c_a[g+1]), .out_b(c_b[g+1]),
      .acc(acc_v[g]), .fin(fin_v[g])
    );
  end

  assign fin_last     = fin_v[NCELL-1];
  assign wr_data      = acc_v[wr_lane];
  assign chain_unused = ^{c_vld[NCELL], c_clr[NCELL], c_last[NCELL],
                          c_a[NCELL], c_b[NCELL], fin_v};
endmodule

// File: rtl/mxm_strip_engine_chk.sv
module mxm_strip_engine_chk #(
  parameter int unsigned NCELL = 4,
  parameter int unsigned LAT   = 19,
  parameter int unsigned DIM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [DIM_W-1:0] dim_m,
  input logic [DIM_W-1:0] dim_k,
  input logic [DIM_W-1:0] dim_n,
  input logic             ready,
  input logic             rd_en,
  input logic [DIM_W-1:0] rd_row,
  input logic [DIM_W-1:0] rd_k,
  input logic [DIM_W-1:0] rd_col0,
  input logic             wr_en,
  input logic [DIM_W-1:0] wr_row,
  input logic [DIM_W-1:0] wr_col
);
  logic [DIM_W-1:0] m_cap, k_cap, n_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cap <= '0;
      k_cap <= '0;
      n_cap <= '0;
    end else if (start && ready) begin
      m_cap <= dim_m;
      k_cap <= dim_k;
      n_cap <= dim_n;
    end
  end

  p_dims_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |-> (dim_m != '0 && dim_k != '0 && dim_n != '0));

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!rd_en && !wr_en));

  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_wr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_col < n_cap && wr_row < m_cap));

  p_rd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_k < k_cap && rd_col0 < n_cap && rd_row < m_cap &&
               (rd_col0 % NCELL) == 0));

  if (LAT > 1) begin : g_space
    p_rd_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
  end
endmodule

bind mxm_strip_engine mxm_strip_engine_chk #(
  .NCELL(NCELL), .LAT(LAT), .DIM_W(DIM_W)
) chk_i (.*);

// File: tb/mxm_strip_engine_tb.sv
module mxm_strip_engine_tb_top;
  localparam int unsigned NCELL  = 3;
  localparam int unsigned LAT    = 5;
  localparam int unsigned DIM_W  = 8;
  localparam time         CLK_PD = 10ns;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [DIM_W-1:0]      dim_m = '0, dim_k = '0, dim_n = '0;
  logic                  ready, rd_en, wr_en;
  logic [DIM_W-1:0]      rd_row, rd_k, rd_col0, wr_row, wr_col;
  logic [31:0]           rd_a = '0;
  logic [NCELL*32-1:0]   rd_b = '0;
  logic [31:0]           wr_data;

  int unsigned total = 0, fails = 0, cyc = 0;
  logic [31:0] seed = 32'h1;
  int unsigned cur_m = 0, cur_k = 0, cur_n = 0;
  int unsigned exp_wi = 0, exp_wj = 0, wcount = 0, rk = 0;
  int unsigned last_rd = 0, last_wr = 0;
  bit need_gap = 1'b0, finished = 1'b0;

  always #(CLK_PD/2) clk = ~clk;

  mxm_strip_engine #(.NCELL(NCELL), .LAT(LAT), .DIM_W(DIM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dim_m(dim_m), .dim_k(dim_k), .dim_n(dim_n), .ready(ready),
    .rd_en(rd_en), .rd_row(rd_row), .rd_k(rd_k), .rd_col0(rd_col0),
    .rd_a(rd_a), .rd_b(rd_b), .wr_en(wr_en), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data)
  );

  function automatic logic [31:0] fa(input int unsigned i, input int unsigned k);
    return (32'(i) * 32'd131 + 32'(k) * 32'd17 + seed) * 32'h9E37_79B1 ^ (32'(k) << 3);
  endfunction

  function automatic logic [31:0] fb(input int unsigned k, input int unsigned j);
    return (32'(k) * 32'd29 + 32'(j) * 32'd101 + (seed << 1)) * 32'h85EB_CA6B ^ 32'(j);
  endfunction

  function automatic logic [31:0] expv(input int unsigned i, input int unsigned j);
    logic [31:0] s = '0;
    for (int unsigned k = 0; k < cur_k; k++) s = s + fa(i, k) * fb(k, j);
    return s;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // Operand file model: answers one cycle after each request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      rd_a <= fa(rd_row, rd_k);
      for (int l = 0; l < NCELL; l++) rd_b[l*32 +: 32] <= fb(rd_k, rd_col0 + l);
    end
  end

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      chk(rd_row == exp_wi, "R6 rd_row", rd_row, exp_wi);
      chk(rd_col0 == exp_wj, "R6 rd_col0", rd_col0, exp_wj);
      chk(rd_k == rk, "R6 rd_k", rd_k, rk);
      if (rk != 0) chk(cyc - last_rd == LAT, "R7 request spacing", cyc - last_rd, LAT);
      last_rd  = cyc;
      rk       = rk + 1;
      need_gap = 1'b1;
    end
    if (rst_n && wr_en) begin
      if (need_gap) begin
        chk(cyc - last_rd == NCELL + LAT + 2, "R9 drain gap", cyc - last_rd, NCELL + LAT + 2);
        chk(rk == cur_k, "R6 requests per strip", rk, cur_k);
      end
      need_gap = 1'b0;
      rk = 0;
      chk(wr_row == exp_wi, "R5 wr_row", wr_row, exp_wi);
      chk(wr_col == exp_wj, "R5 wr_col", wr_col, exp_wj);
      if (exp_wi == 0 && exp_wj < NCELL)
        chk(wr_data == expv(exp_wi, exp_wj), "R8 first strip clear", wr_data, expv(exp_wi, exp_wj));
      else
        chk(wr_data == expv(exp_wi, exp_wj), "R4 result word", wr_data, expv(exp_wi, exp_wj));
      last_wr = cyc;
      wcount++;
      exp_wj++;
      if (exp_wj >= cur_n) begin
        exp_wj = 0;
        exp_wi++;
      end
    end
  end

  task automatic run_case(input int unsigned m, input int unsigned k,
                          input int unsigned n, input bit poke);
    int unsigned waited = 0;
    @(negedge clk);
    seed   = seed * 32'd1103515245 + 32'd12345;
    cur_m  = m; cur_k = k; cur_n = n;
    exp_wi = 0; exp_wj = 0; wcount = 0; rk = 0; need_gap = 1'b0;
    dim_m  = DIM_W'(m); dim_k = DIM_W'(k); dim_n = DIM_W'(n);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    chk(ready == 1'b0, "R2 ready falls", 32'(ready), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      dim_m = DIM_W'(m + 1); dim_k = DIM_W'(k + 2); dim_n = DIM_W'(n + 3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(ready == 1'b0, "R3 busy start ignored", 32'(ready), 0);
    end
    while (!ready && waited < 30000) begin
      @(negedge clk);
      waited++;
    end
    chk(ready == 1'b1, "R2 ready returns", 32'(ready), 1);
    chk(cyc == last_wr + 1, "R2 ready after last write", cyc, last_wr + 1);
    if (poke) chk(wcount == m * n, "R3 write count", wcount, m * n);
    else      chk(wcount == m * n, "R5 write count", wcount, m * n);
  endtask

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      fails++;
      total++;
      $display("FAIL watchdog R2 actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", 32'(ready), 1);
    chk(rd_en == 1'b0, "R1 rd_en after reset", 32'(rd_en), 0);
    chk(wr_en == 1'b0, "R1 wr_en after reset", 32'(wr_en), 0);
    for (int unsigned m = 1; m <= 3; m++)
      for (int unsigned k = 1; k <= 4; k++)
        for (int unsigned n = 1; n <= 7; n++)
          run_case(m, k, n, (k >= 2) && (n % 2 == 0));
    run_case(3, 4, 7, 1'b0);
    run_case(1, 1, 1, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule